// File: doc/BRIEF.md
# Sequential Long-by-Word Divider

This block divides a 32-bit dividend by a 16-bit divisor over several clocks, in either signed or unsigned mode, chosen per operation. The outcome comes back packed into a single 32-bit word: the 16-bit quotient in the low half and the 16-bit remainder in the high half. The word is ready to be written back to the register that supplied the dividend. When the quotient does not fit in 16 bits, or the divisor is zero, the result word returns the dividend unchanged. Flags report the error in each case.

Control is a plain start/busy handshake. `busy` acts as the inverse of a ready signal, and a `start` pulse is taken only on an edge where `busy` is low. A `start` raised while an operation runs is dropped, so the caller must hold off. The outputs carry no back-pressure. `done` is a one-cycle pulse, and `result` and the flags stay valid until the next `done`.

The datapath is a restoring divider that forms one quotient bit per clock on operand magnitudes. It has one setup cycle before the iterations and one sign-correction cycle after them.

Top module: `divq_unit`

## Requirements
- R1: In unsigned mode (`sgn_mode`=0) a successful operation returns `result[15:0]` = floor(dividend/divisor) and `result[31:16]` = dividend mod divisor.
- R2: In signed mode (`sgn_mode`=1) both operands are two's complement. The quotient is truncated toward zero, the remainder has the sign of the dividend, and each is placed in its half of `result` as 16-bit two's complement.
- R3: If the true quotient lies outside 0..65535 (unsigned) or -32768..32767 (signed), `ovf` and `flag_v` are set and `result` equals the original dividend.
- R4: A zero divisor sets `dz`, clears `ovf` and `flag_v`, and returns the original dividend in `result`. `ovf` and `dz` are never set together.
- R5: `done` is a one-clock pulse seen after the 18th rising edge that follows the accepting edge. It comes after the 1st edge instead when the divisor is zero or the upper 16 bits of the dividend magnitude are at least the divisor magnitude. `busy` is high from the accepting edge until the edge that raises `done`.
- R6: `flag_c` is always 0. On success `flag_v`=0, `flag_n` equals quotient bit 15 and `flag_z` is set when the 16-bit quotient is zero. On overflow or divide-by-zero `flag_n` and `flag_z` are 0.
- R7: A `start` asserted while `busy` is high is ignored. It produces no extra `done`, and the running operation's result is unchanged.
- R8: After reset `busy`, `done`, `result`, `ovf`, `dz` and all condition flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; taken when `busy` is low |
| sgn_mode | input | 1 | 1 = signed division, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled at the accepting edge |
| divisor | input | 16 | Divisor, sampled at the accepting edge |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Remainder in bits 31:16, quotient in bits 15:0, or the dividend on error |
| ovf | output | 1 | Quotient out of range |
| dz | output | 1 | Divisor was zero |
| flag_n | output | 1 | Quotient negative |
| flag_z | output | 1 | Quotient zero |
| flag_v | output | 1 | Overflow condition flag |
| flag_c | output | 1 | Carry condition flag, always clear |

## Verification
An operation that runs the full iteration finishes 18 edges after it is accepted. An operation caught early, because the divisor is zero or the quotient plainly cannot fit, finishes after a single edge. A signed overflow found only after iteration still takes the full 18 edges. The driver stamps each queued expectation with the cycle number of its accepting edge and with the latency the bench derives from the operands. The monitor samples on the falling clock edge, pops an expectation on each `done`, and compares the result, the flags and the elapsed cycle count. A `done` that arrives with nothing queued is counted as an error, and this catches a `start` accepted while busy.

// File: rtl/divq_pkg.sv
package divq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ITER  = 2'd2,
    ST_FIX   = 2'd3
  } divq_state_e;
endpackage

// File: rtl/divq_prep.sv
// Operand conditioning: magnitudes, sign bookkeeping, early exits.
module divq_prep #(
  parameter int QW = 16,
  localparam int DW = 2 * QW
) (
  input  logic [DW-1:0] dvd,
  input  logic [QW-1:0] dvs,
  input  logic          sgn,
  output logic [DW-1:0] mag_dvd,
  output logic [QW-1:0] mag_dvs,
  output logic          neg_q,
  output logic          neg_r,
  output logic          zero_dvs,
  output logic          early_ovf
);
  logic neg_dvd, neg_dvs;

  always_comb begin
    neg_dvd   = sgn & dvd[DW-1];
    neg_dvs   = sgn & dvs[QW-1];
    mag_dvd   = neg_dvd ? (~dvd + DW'(1)) : dvd;
    mag_dvs   = neg_dvs ? (~dvs + QW'(1)) : dvs;
    neg_q     = neg_dvd ^ neg_dvs;
    neg_r     = neg_dvd;
    zero_dvs  = (dvs == '0);
    // upper half >= divisor means the magnitude quotient needs more than QW bits
    early_ovf = !zero_dvs && (mag_dvd[DW-1:QW] >= mag_dvs);
  end
endmodule

// File: rtl/divq_step.sv
// One restoring iteration: shift in the next dividend bit, trial-subtract.
module divq_step #(
  parameter int QW = 16
) (
  input  logic [QW-1:0] p_in,
  input  logic [QW-1:0] q_in,
  input  logic [QW-1:0] d_in,
  output logic [QW-1:0] p_out,
  output logic [QW-1:0] q_out
);
  logic [QW:0]   shifted;
  logic          fits;
  logic [QW-1:0] diff;

  always_comb begin
    shifted = {p_in, q_in[QW-1]};
    fits    = (shifted >= {1'b0, d_in});
    diff    = shifted[QW-1:0] - d_in;
    p_out   = fits ? diff : shifted[QW-1:0];
    q_out   = {q_in[QW-2:0], fits};
  end
endmodule

// File: rtl/divq_fix.sv
// Sign restoration and late range check for the signed mode.
module divq_fix #(
  parameter int QW = 16
) (
  input  logic [QW-1:0] q_mag,
  input  logic [QW-1:0] r_mag,
  input  logic          neg_q,
  input  logic          neg_r,
  input  logic          sgn,
  output logic [QW-1:0] q_val,
  output logic [QW-1:0] r_val,
  output logic          range_err
);
  localparam logic [QW-1:0] NEG_LIMIT = {1'b1, {(QW-1){1'b0}}};

  always_comb begin
    q_val     = neg_q ? (~q_mag + QW'(1)) : q_mag;
    r_val     = neg_r ? (~r_mag + QW'(1)) : r_mag;
    range_err = sgn & (neg_q ? (q_mag > NEG_LIMIT) : q_mag[QW-1]);
  end
endmodule

// File: rtl/divq_unit.sv
module divq_unit #(
  parameter int QW = 16,
  localparam int DW = 2 * QW,
  localparam int CW = $clog2(QW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sgn_mode,
  input  logic [DW-1:0] dividend,
  input  logic [QW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result,
  output logic          ovf,
  output logic          dz,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_v,
  output logic          flag_c
);
  import divq_pkg::*;

  divq_state_e   state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] dvd_r;
  logic [QW-1:0] dvs_r;
  logic          sgn_r, neg_q_r, neg_r_r;
  logic [QW-1:0] mag_dvs_r;
  logic [QW-1:0] p_r, q_r;

  logic [DW-1:0] mag_dvd;
  logic [QW-1:0] mag_dvs;
  logic          neg_q, neg_r, zero_dvs, early_ovf;
  logic [QW-1:0] p_nx, q_nx;
  logic [QW-1:0] q_val, r_val;
  logic          range_err;

  divq_prep #(.QW(QW)) prep_i (
    .dvd(dvd_r), .dvs(dvs_r), .sgn(sgn_r),
    .mag_dvd(mag_dvd), .mag_dvs(mag_dvs),
    .neg_q(neg_q), .neg_r(neg_r),
    .zero_dvs(zero_dvs), .early_ovf(early_ovf)
  );

  divq_step #(.QW(QW)) step_i (
    .p_in(p_r), .q_in(q_r), .d_in(mag_dvs_r),
    .p_out(p_nx), .q_out(q_nx)
  );

  divq_fix #(.QW(QW)) fix_i (
    .q_mag(q_r), .r_mag(p_r), .neg_q(neg_q_r), .neg_r(neg_r_r),
    .sgn(sgn_r), .q_val(q_val), .r_val(r_val), .range_err(range_err)
  );

  assign busy   = (state != ST_IDLE);
  assign flag_c = 1'b0;
  assign flag_v = ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      dvd_r     <= '0;
      dvs_r     <= '0;
      sgn_r     <= 1'b0;
      neg_q_r   <= 1'b0;
      neg_r_r   <= 1'b0;
      mag_dvs_r <= '0;
      p_r       <= '0;
      q_r       <= '0;
      done      <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
      dz        <= 1'b0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            dvd_r <= dividend;
            dvs_r <= divisor;
            sgn_r <= sgn_mode;
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (zero_dvs || early_ovf) begin
            result <= dvd_r;
            ovf    <= early_ovf;
            dz     <= zero_dvs;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            p_r       <= mag_dvd[DW-1:QW];
            q_r       <= mag_dvd[QW-1:0];
            mag_dvs_r <= mag_dvs;
            neg_q_r   <= neg_q;
            neg_r_r   <= neg_r;
            cnt       <= '0;
            state     <= ST_ITER;
          end
        end
        ST_ITER: begin
          p_r <= p_nx;
          q_r <= q_nx;
          cnt <= cnt + CW'(1);
          if (cnt == CW'(QW - 1)) state <= ST_FIX;
        end
        ST_FIX: begin
          dz    <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
          if (range_err) begin
            result <= dvd_r;
            ovf    <= 1'b1;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
          end else begin
            result <= {r_val, q_val};
            ovf    <= 1'b0;
            flag_n <= q_val[QW-1];
            flag_z <= (q_val == '0);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/divq_chk.sv
module divq_chk #(
  parameter int QW = 16,
  localparam int DW = 2 * QW,
  localparam int FULL_LAT = QW + 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] dividend,
  input logic [DW-1:0] result,
  input logic          ovf,
  input logic          dz,
  input logic          flag_z
);
  logic [DW-1:0] cap_dvd;
  int unsigned   lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_dvd <= '0;
      lat     <= 0;
    end else if (start && !busy) begin
      cap_dvd <= dividend;
      lat     <= 0;
    end else if (busy) begin
      lat <= lat + 1;
    end
  end

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat == FULL_LAT || lat == 1));
  assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_err_keeps_dividend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (ovf || dz)) |-> (result == cap_dvd));
  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(ovf && dz));
  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ovf && !dz) |-> (flag_z == (result[QW-1:0] == '0)));
endmodule

bind divq_unit divq_chk #(.QW(QW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .dividend(dividend), .result(result), .ovf(ovf), .dz(dz), .flag_z(flag_z)
);

// File: tb/divq_unit_tb_top.sv
`timescale 1ns/1ps
module divq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sgn_mode = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, ovf, dz, flag_n, flag_z, flag_v, flag_c;
  logic [31:0] result;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] res;
    logic        ovf, dz, n, z, v;
    int          acc;
    int          lat;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  divq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sgn_mode(sgn_mode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .result(result), .ovf(ovf), .dz(dz), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [31:0] a, input logic [15:0] b,
                                 input logic s);
    exp_t e;
    longint sd, sv, qq, rr, md, mv;
    bit bad;
    e.dz = (b == 0);
    if (s) begin sd = longint'($signed(a)); sv = longint'($signed(b)); end
    else   begin sd = longint'({32'b0, a}); sv = longint'({48'b0, b}); end
    qq = 0; rr = 0;
    if (!e.dz) begin qq = sd / sv; rr = sd % sv; end
    e.ovf = !e.dz && (s ? (qq > 32767 || qq < -32768) : (qq > 65535));
    bad = e.dz || e.ovf;
    md = (sd < 0) ? -sd : sd;
    mv = (sv < 0) ? -sv : sv;
    e.lat = (e.dz || ((md >>> 16) >= mv)) ? 1 : 18;
    e.res = bad ? a : {rr[15:0], qq[15:0]};
    e.n = bad ? 1'b0 : qq[15];
    e.z = bad ? 1'b0 : (qq[15:0] == 16'h0);
    e.v = e.ovf;
    e.tag = e.dz ? "R4" : (e.ovf ? "R3" : (s ? "R2" : "R1"));
    return e;
  endfunction

  task automatic issue(input logic [31:0] a, input logic [15:0] b, input logic s,
                       input bit poke_busy);
    exp_t e;
    e = model(a, b, s);
    @(negedge clk);
    start = 1'b1; sgn_mode = s; dividend = a; divisor = b;
    e.acc = cyc + 1;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      // R7: a second request while busy must be dropped
      repeat (3) @(negedge clk);
      start = 1'b1; sgn_mode = ~s; dividend = 32'h0000_0064; divisor = 16'h0007;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done && !finished) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R7", "unexpected done", 32'h1, 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(result == e.res, e.tag, "result", result, e.res);
        chk(ovf == e.ovf && flag_v == e.v, "R3", "overflow flags",
            {ovf, flag_v}, {e.ovf, e.v});
        chk(dz == e.dz, "R4", "dz", dz, e.dz);
        chk(flag_n == e.n && flag_z == e.z && flag_c == 1'b0, "R6", "N/Z/C",
            {flag_n, flag_z, flag_c}, {e.n, e.z, 1'b0});
        chk(cyc - e.acc == e.lat, "R5", "latency", cyc - e.acc, e.lat);
        chk(!busy, "R5", "busy at done", busy, 1'b0);
      end
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk({busy, done, ovf, dz, flag_n, flag_z, flag_v, flag_c} == 8'h0, "R8",
        "control/flags after reset", {busy, done, ovf, dz, flag_n, flag_z, flag_v, flag_c}, 0);
    chk(result == 32'h0, "R8", "result after reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    issue(32'd100, 16'd7, 1'b0, 0);          // R1
    issue(32'd0, 16'd5, 1'b0, 0);            // R1, R6 zero quotient
    issue(32'h0001_0000, 16'd2, 1'b0, 0);    // R1, R6 negative bit
    issue(32'hFFFF_0000, 16'hFFFF, 1'b0, 0); // R3 early
    issue(32'h0000_0005, 16'h0000, 1'b0, 0); // R4
    issue(32'hFFFF_FFF9, 16'd2, 1'b1, 0);    // R2: -7/2
    issue(32'd7, 16'hFFFE, 1'b1, 0);         // R2: 7/-2
    issue(32'hFFFF_0000, 16'd2, 1'b1, 0);    // R2: -32768 fits
    issue(32'h0001_0000, 16'd2, 1'b1, 0);    // R3: late signed overflow
    issue(32'h8000_0000, 16'hFFFF, 1'b1, 0); // R3: early signed overflow
    issue(32'h1234_5678, 16'h0000, 1'b1, 0); // R4 signed
    issue(32'h0012_3456, 16'h4321, 1'b0, 1); // R7 start while busy
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a;
      logic [15:0] b;
      a = $urandom();
      b = $urandom();
      if (i % 2 == 0) a = {16'h0, a[15:0]} ^ {a[31] ? 16'hFFFF : 16'h0, 16'h0};
      issue(a, b, i[0], 0);
    end
    repeat (30) @(negedge clk);
    chk(sb.size() == 0, "R7", "pending expectations", sb.size(), 0);
    summary();
  end
endmodule